// File: doc/BRIEF.md
# Prioritised Memory Access Permission Checker

This block decides whether one memory access may proceed. It takes the access address, the size in bytes, the requested read/write/execute set and the privilege mode. It also takes, for every protection entry, the already decoded inclusive lower and upper bounds and an 8-bit entry configuration byte. Further inputs are the count of active rules and three control bits: lockdown, deny-by-default (whitelist) and translation-present.

The entries are searched from the lowest index to the highest. The first entry that holds both ends of the access and is not switched off supplies the allowed permission set. Without lockdown the classic rules give that set. With lockdown a 16-way table gives it, with separate results for machine mode and for lower modes. An access that straddles an entry's edge is refused at once. When no entry decides, or no rules are active, a fixed default policy applies.

The search is a combinational priority chain. The grant flag and the allowed set are registered, so they appear one cycle after the request. Bounds decoding and register storage sit outside this block.

Top module: `perm_checker`

## Requirements
- R1: The access spans `req_addr` through `req_addr+req_size-1`, modulo 2^AW. When `req_size` is 0, the span ends at the last byte of the 4 KiB page (`req_addr | 0xFFF`) if `xlate_on` is 1, and otherwise covers AW/8 bytes.
- R2: Entries are examined in increasing index order. The first entry whose bounds hold both ends of the span and whose match field (config bits [4:3]) is nonzero decides the result, and later entries are ignored.
- R3: If, before any deciding entry, an entry holds exactly one end of the span, the access is denied with an empty allowed set. This applies whatever that entry's match field is.
- R4: Without lockdown, a matching entry allows R, W and X in machine mode (`req_mode` = 3) unless its lock bit (config bit 7) is set. A locked entry, or any access in a lower mode, is allowed only the entry's config bits [2:0] (bit 0 read, bit 1 write, bit 2 execute).
- R5: With lockdown and machine mode, the table index is {lock, read, write, execute}. Indices 2, 3 and 14 give RW; 9 and 10 give X; 11 and 13 give RX; 12 and 15 give R; every other index gives nothing.
- R6: With lockdown and a lower mode, indices 1, 10 and 11 give X; 2, 4 and 15 give R; 3 and 6 give RW; 5 gives RX; 7 gives RWX; every other index gives nothing.
- R7: The grant flag is 1 exactly when every requested permission (bit 0 read, bit 1 write, bit 2 execute) is in the allowed set. A partial overlap is never granted.
- R8: When no entry decides, or `rule_cnt` is 0, the defaults apply in this order. With whitelist set, the access is denied and the allowed set is empty. Otherwise, with lockdown set, a machine-mode access without execute is granted with RW allowed, and anything else is denied with an empty set. Otherwise a machine-mode access is granted with RWX, and a lower-mode access is denied with an empty set.
- R9: `rsp_valid`, `rsp_grant` and `rsp_allow` are registered. The result of a request appears on the clock edge after the one that samples `req_valid`. A cycle without a request yields zeros, and so does reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_addr | input | AW | Access start address |
| req_size | input | SZW | Access size in bytes, 0 = unknown |
| req_perm | input | 3 | Requested permissions {X,W,R} |
| req_mode | input | 2 | Privilege mode, 3 = machine |
| xlate_on | input | 1 | Address translation present |
| lockdown | input | 1 | Enhanced lockdown rules enabled |
| deny_dflt | input | 1 | Whitelist: deny unmatched accesses |
| rule_cnt | input | CW | Number of active rules |
| ent_lo | input | N*AW | Entry inclusive lower bounds, entry i at [i*AW +: AW] |
| ent_hi | input | N*AW | Entry inclusive upper bounds |
| ent_cfg | input | N*8 | Entry config bytes: [2:0] RWX, [4:3] match (0 = off), [7] lock |
| rsp_valid | output | 1 | Result valid |
| rsp_grant | output | 1 | Access granted |
| rsp_allow | output | 3 | Allowed permission set {X,W,R} |

## Verification
Random entry layouts in a small address window produce a mix of full hits, edge straddles and misses. Random config bytes, modes and control bits exercise the classic path, both lockdown tables and every default branch, and each result is compared against an independent reference function. Directed cases separate what random runs rarely isolate. A bound one byte short of the page end shows whether the zero-size span follows `xlate_on`. Overlapping entries with different permissions show whether the lowest index wins and whether an entry that is off is skipped. An edge straddle in front of a full hit must deny. A sweep of all 16 lockdown indices in both modes pins down each table cell, and a zero rule count with a matching entry shows that the defaults take over.

// File: rtl/perm_checker_pkg.sv
// Shared types, config-byte field positions and lockdown permission tables.
// Assumes permission sets are encoded {X,W,R} (bit 0 read).
package perm_checker_pkg;
    typedef logic [2:0] perm_t;

    localparam int          CFG_LOCK  = 7;
    localparam logic [1:0]  MODE_MACH = 2'd3;
    localparam perm_t       P_NONE = 3'b000, P_R = 3'b001, P_RW = 3'b011,
                            P_X = 3'b100, P_RX = 3'b101, P_RWX = 3'b111;

    // Lockdown table for machine mode, index = {lock, read, write, execute}.
    function automatic perm_t lock_mach(input logic [3:0] idx);
        case (idx)
            4'd2, 4'd3, 4'd14: return P_RW;
            4'd9, 4'd10:       return P_X;
            4'd11, 4'd13:      return P_RX;
            4'd12, 4'd15:      return P_R;
            default:           return P_NONE;
        endcase
    endfunction

    // Lockdown table for lower modes, same index.
    function automatic perm_t lock_low(input logic [3:0] idx);
        case (idx)
            4'd1, 4'd10, 4'd11: return P_X;
            4'd2, 4'd4, 4'd15:  return P_R;
            4'd3, 4'd6:         return P_RW;
            4'd5:               return P_RX;
            4'd7:               return P_RWX;
            default:            return P_NONE;
        endcase
    endfunction
endpackage

// File: rtl/perm_span.sv
// Computes the last byte address of an access.
// Assumes AW is a multiple of 8 and at least 16; arithmetic wraps modulo 2^AW.
module perm_span #(
    parameter int AW = 32,
    parameter int SZW = 8,
    parameter int PAGE_BITS = 12
) (
    input  logic [AW-1:0]  addr,
    input  logic [SZW-1:0] size,
    input  logic           xlate_on,
    output logic [AW-1:0]  last
);
    localparam logic [AW-1:0] PAGE_MASK = AW'((64'd1 << PAGE_BITS) - 64'd1);
    localparam logic [AW-1:0] WORD_LAST = AW'(AW / 8 - 1);

    // Pick the span end from size, or from page/word width when size is 0.
    always_comb begin
        if (size != '0)
            last = addr + AW'(size) - AW'(1);
        else if (xlate_on)
            last = addr | PAGE_MASK;
        else
            last = addr + WORD_LAST;
    end
endmodule

// File: rtl/perm_entry_hit.sv
// Compares both ends of an access with one entry's inclusive bounds.
// Assumes the bounds are already decoded; no config is looked at here.
module perm_entry_hit #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] hi,
    input  logic [AW-1:0] first,
    input  logic [AW-1:0] last,
    output logic          both,
    output logic          one
);
    logic first_in, last_in;

    // Range test of each end, then classify full versus partial containment.
    always_comb begin
        first_in = (first >= lo) && (first <= hi);
        last_in  = (last >= lo) && (last <= hi);
        both     = first_in && last_in;
        one      = first_in ^ last_in;
    end
endmodule

// File: rtl/perm_resolve.sv
// Lowest-index-wins priority chain over entry hits, permission selection
// (classic or lockdown) and the default policy. Purely combinational.
module perm_resolve
    import perm_checker_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [N-1:0]   both,
    input  logic [N-1:0]   one,
    input  logic [N*8-1:0] cfg,
    input  logic           rules_none,
    input  logic [1:0]     mode,
    input  perm_t          want,
    input  logic           lockdown,
    input  logic           deny_dflt,
    output logic           grant,
    output perm_t          allow
);
    logic       found;
    logic       is_mach;
    logic [7:0] c;
    logic [3:0] idx;

    // Walk entries low to high; first partial or full active hit decides.
    always_comb begin
        found   = 1'b0;
        grant   = 1'b0;
        allow   = P_NONE;
        is_mach = (mode == MODE_MACH);
        c       = '0;
        idx     = '0;
        if (!rules_none) begin
            for (int i = 0; i < N; i++) begin
                if (!found) begin
                    c   = cfg[i*8 +: 8];
                    idx = {c[CFG_LOCK], c[0], c[1], c[2]};
                    if (one[i]) begin
                        found = 1'b1;
                        allow = P_NONE;
                        grant = 1'b0;
                    end else if (both[i] && (c[4:3] != 2'b00)) begin
                        found = 1'b1;
                        if (!lockdown)
                            allow = (is_mach && !c[CFG_LOCK]) ? P_RWX : c[2:0];
                        else
                            allow = is_mach ? lock_mach(idx) : lock_low(idx);
                        grant = ((want & ~allow) == P_NONE);
                    end
                end
            end
        end
        if (!found) begin
            if (deny_dflt) begin
                grant = 1'b0;
                allow = P_NONE;
            end else if (lockdown) begin
                grant = is_mach && !want[2];
                allow = grant ? P_RW : P_NONE;
            end else begin
                grant = is_mach;
                allow = is_mach ? P_RWX : P_NONE;
            end
        end
    end
endmodule

// File: rtl/perm_checker.sv
// Top: span computation, per-entry hit detection (generated), priority
// resolution and a one-cycle output register. Assumes bounds are decoded
// inclusive and config bytes use [2:0] RWX, [4:3] match, [7] lock.
module perm_checker
    import perm_checker_pkg::*;
#(
    parameter int N = 16,
    parameter int AW = 32,
    parameter int SZW = 8,
    parameter int PAGE_BITS = 12,
    localparam int CW = $clog2(N + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [AW-1:0]   req_addr,
    input  logic [SZW-1:0]  req_size,
    input  logic [2:0]      req_perm,
    input  logic [1:0]      req_mode,
    input  logic            xlate_on,
    input  logic            lockdown,
    input  logic            deny_dflt,
    input  logic [CW-1:0]   rule_cnt,
    input  logic [N*AW-1:0] ent_lo,
    input  logic [N*AW-1:0] ent_hi,
    input  logic [N*8-1:0]  ent_cfg,
    output logic            rsp_valid,
    output logic            rsp_grant,
    output logic [2:0]      rsp_allow
);
    logic [AW-1:0] span_last;
    logic [N-1:0]  hit_both, hit_one;
    logic          nxt_grant;
    perm_t         nxt_allow;

    perm_span #(.AW(AW), .SZW(SZW), .PAGE_BITS(PAGE_BITS)) u_span (
        .addr(req_addr), .size(req_size), .xlate_on(xlate_on), .last(span_last)
    );

    for (genvar g = 0; g < N; g++) begin : g_ent
        perm_entry_hit #(.AW(AW)) u_hit (
            .lo(ent_lo[g*AW +: AW]), .hi(ent_hi[g*AW +: AW]),
            .first(req_addr), .last(span_last),
            .both(hit_both[g]), .one(hit_one[g])
        );
    end

    perm_resolve #(.N(N)) u_res (
        .both(hit_both), .one(hit_one), .cfg(ent_cfg),
        .rules_none(rule_cnt == '0), .mode(req_mode), .want(req_perm),
        .lockdown(lockdown), .deny_dflt(deny_dflt),
        .grant(nxt_grant), .allow(nxt_allow)
    );

    // Register the decision; idle cycles and reset yield zeros.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_grant <= 1'b0;
            rsp_allow <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_grant <= req_valid && nxt_grant;
            rsp_allow <= req_valid ? nxt_allow : '0;
        end
    end

    // R9
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R9
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_grant && rsp_allow == '0));
    // R7
    grant_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_grant) |-> (($past(req_perm) & ~rsp_allow) == '0));
    // R8
    wl_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && deny_dflt && rule_cnt == '0) |=> (!rsp_grant && rsp_allow == '0));
    // R3
    part0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rule_cnt != '0 && hit_one[0]) |=> (!rsp_grant && rsp_allow == '0));
    // R4
    mach_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rule_cnt != '0 && !lockdown && req_mode == MODE_MACH &&
         hit_both[0] && ent_cfg[4:3] != 2'b00 && !ent_cfg[CFG_LOCK])
        |=> (rsp_grant && rsp_allow == 3'b111));
endmodule

// File: tb/perm_checker_test.sv
module perm_checker_test;
    localparam int N = 16;
    localparam int AW = 32;
    localparam int SZW = 8;
    localparam int CW = $clog2(N + 1);
    localparam logic [2:0] MT [16] = '{0,0,3,3,0,0,0,0,0,4,4,5,1,5,3,1};
    localparam logic [2:0] LT [16] = '{0,4,1,3,1,5,3,7,0,0,4,4,0,0,0,1};

    logic clk = 0, rst_n = 0;
    logic req_valid = 0;
    logic [AW-1:0] addr = '0;
    logic [SZW-1:0] size = '0;
    logic [2:0] perm = '0;
    logic [1:0] mode = '0;
    logic mmu = 0, lock = 0, wl = 0;
    logic [CW-1:0] rcnt = '0;
    logic [AW-1:0] lo [N];
    logic [AW-1:0] hi [N];
    logic [7:0] cfg [N];
    logic [N*AW-1:0] lo_f, hi_f;
    logic [N*8-1:0] cfg_f;
    logic rsp_valid, rsp_grant;
    logic [2:0] rsp_allow;
    int checks = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            lo_f[i*AW +: AW] = lo[i];
            hi_f[i*AW +: AW] = hi[i];
            cfg_f[i*8 +: 8] = cfg[i];
        end
    end

    perm_checker uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(addr),
        .req_size(size), .req_perm(perm), .req_mode(mode), .xlate_on(mmu),
        .lockdown(lock), .deny_dflt(wl), .rule_cnt(rcnt),
        .ent_lo(lo_f), .ent_hi(hi_f), .ent_cfg(cfg_f),
        .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_allow(rsp_allow)
    );

    // Reference: returns {grant, allow}
    function automatic logic [3:0] model();
        logic [AW-1:0] e;
        logic fi, li;
        logic [2:0] al;
        logic [3:0] ix;
        if (size == 0) e = mmu ? (addr | 32'hFFF) : addr + 32'd3;
        else e = addr + {24'd0, size} - 32'd1;
        if (rcnt != 0) begin
            for (int i = 0; i < N; i++) begin
                fi = (addr >= lo[i]) && (addr <= hi[i]);
                li = (e >= lo[i]) && (e <= hi[i]);
                if (fi != li) return 4'b0000;
                if (fi && li && cfg[i][4:3] != 0) begin
                    ix = {cfg[i][7], cfg[i][0], cfg[i][1], cfg[i][2]};
                    if (!lock) al = (mode == 3 && !cfg[i][7]) ? 3'b111 : cfg[i][2:0];
                    else al = (mode == 3) ? MT[ix] : LT[ix];
                    return {((perm & ~al) == 0), al};
                end
            end
        end
        if (wl) return 4'b0000;
        if (lock) return (mode == 3 && !perm[2]) ? 4'b1011 : 4'b0000;
        return (mode == 3) ? 4'b1111 : 4'b0000;
    endfunction

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    // Drive at a negedge, compare at the next negedge (one register stage).
    task automatic run(input string tag);
        logic [3:0] ex;
        ex = model();
        req_valid = 1;
        @(negedge clk);
        checks++;
        if (!rsp_valid || rsp_grant !== ex[3] || rsp_allow !== ex[2:0]) begin
            fails++;
            $display("FAIL %s: got v=%0b g=%0b a=%03b, expected v=1 g=%0b a=%03b",
                     tag, rsp_valid, rsp_grant, rsp_allow, ex[3], ex[2:0]);
        end
    endtask

    task automatic clear_entries();
        for (int i = 0; i < N; i++) begin
            lo[i] = 32'hFFFF_FF00; hi[i] = 32'hFFFF_FFFF; cfg[i] = 8'h00;
        end
    endtask

    initial begin
        #(4 * 150000);
        checks++; fails++;
        $display("FAIL watchdog: got hung run, expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'd1234));
        clear_entries();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R9 reset / idle state
        checks++;
        if (rsp_valid || rsp_grant || rsp_allow != 0) begin
            fails++;
            $display("FAIL R9 reset: got v=%0b g=%0b a=%03b, expected 0 0 000",
                     rsp_valid, rsp_grant, rsp_allow);
        end

        // R1: zero size, page end vs word width
        rcnt = 1; mode = 0; perm = 3'b001; lock = 0; wl = 0;
        lo[0] = 32'h1000; hi[0] = 32'h1FFE; cfg[0] = 8'h09;
        addr = 32'h1800; size = 0; mmu = 1; run("R1 page span straddles");
        mmu = 0; run("R1 word span inside");
        size = 8'd255; run("R1 explicit size");

        // R2: lowest index wins; off entry skipped
        lo[0] = 32'h2000; hi[0] = 32'h2FFF; cfg[0] = 8'h09;
        lo[1] = 32'h2000; hi[1] = 32'h2FFF; cfg[1] = 8'h0F;
        addr = 32'h2100; size = 4; perm = 3'b010; run("R2 first entry wins");
        cfg[0] = 8'h01; run("R2 off entry skipped");

        // R3: partial in entry 0 beats full hit in entry 1
        cfg[0] = 8'h0F; hi[0] = 32'h2101; run("R3 partial deny");
        hi[0] = 32'h2FFF;

        // R4: classic machine mode, locked / unlocked
        mode = 3; perm = 3'b100; cfg[0] = 8'h09; run("R4 machine unlocked");
        cfg[0] = 8'h89; run("R4 machine locked");
        mode = 1; cfg[0] = 8'h0B; perm = 3'b011; run("R4 lower mode cfg bits");

        // R5 / R6: lockdown tables, all indices
        lock = 1;
        for (int m = 0; m < 2; m++) begin
            mode = m ? 2'd3 : 2'd1;
            for (int k = 0; k < 16; k++) begin
                cfg[0] = {k[3], 2'b00, 2'b01, k[0], k[1], k[2]};
                perm = 3'b000;
                run(m ? "R5 machine table" : "R6 lower table");
            end
        end
        perm = 3'b001; run("R7 subset under lockdown");

        // R8: defaults
        rcnt = 0; mode = 3; perm = 3'b011; run("R8 lockdown machine default");
        perm = 3'b100; run("R8 lockdown exec denied");
        lock = 0; run("R8 machine default");
        mode = 0; run("R8 lower default deny");
        wl = 1; mode = 3; run("R8 whitelist deny");
        wl = 0; rcnt = 3; addr = 32'h8000; run("R8 no match");

        // Random mix
        for (int it = 0; it < 600; it++) begin
            for (int i = 0; i < N; i++) begin
                lo[i] = $urandom % 4096;
                hi[i] = lo[i] + ($urandom % 256);
                cfg[i] = 8'($urandom);
            end
            addr = $urandom % 4352;
            size = 8'($urandom % 9);
            perm = 3'($urandom);
            case ($urandom % 3) 0: mode = 0; 1: mode = 1; default: mode = 3; endcase
            lock = 1'($urandom); wl = ($urandom % 8 == 0); mmu = 1'($urandom);
            rcnt = ($urandom % 6 == 0) ? 0 : CW'(1 + $urandom % N);
            run("R2 R4 R5 R6 R7 R8 random");
        end

        req_valid = 0;
        @(negedge clk);
        checks++;
        if (rsp_valid || rsp_grant || rsp_allow != 0) begin
            fails++;
            $display("FAIL R9 idle: got v=%0b g=%0b a=%03b, expected 0 0 000",
                     rsp_valid, rsp_grant, rsp_allow);
        end
        summary();
    end
endmodule